// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz time-base enable, delivered as a one-cycle strobe in the system clock domain, into a periodic event for a real-time-clock interrupt path. A four-bit rate code sets the interval as a power of two of the time-base period. A three-bit divider-control field can stop the divider, freeze it, or hold it cleared. An enable bit in a second control byte gates the output. Each event is a single system-clock pulse. A matching byte mask is driven alongside it, which the owner of the interrupt status register ORs into that register. That mask sets the interrupt-request bit and the periodic-flag bit.

Rate codes 1 and 2 do not give faster rates. They alias to codes 8 and 9. Any change to the rate code or to the enable bit restarts the divider, so the first event after a reprogram always comes one full period later.

Top module: `periodic_irq_gen`

## Requirements
- R1: With rate code `ctrl_a_i[3:0]` equal to 0, no event is produced, whatever the ticks.
- R2: For rate code n from 3 to 15, with the divider running and enabled, events come every 2^(n-1) ticks. The first event follows the 2^(n-1)-th tick after a restart.
- R3: Rate codes 1 and 2 give the same periods as codes 8 and 9 (128 and 256 ticks).
- R4: When divider-control bits `ctrl_a_i[6:5]` are 00, ticks are not counted and no event occurs. The count is held, so on return to a running setting the period resumes where it stopped.
- R5: When `ctrl_a_i[6:5]` are 11, the divider is held cleared and no event occurs. On return to a running setting, a full period is needed.
- R6: Divider-control values 010, 011, 100 and 101 all run the divider at the programmed rate.
- R7: Events occur only while enable bit `ctrl_b_i[6]` is 1. Clearing the bit stops events. Setting it again restarts the divider, so the next event needs a full period.
- R8: An event is a one-cycle high on `evt_o` in the cycle after the clock edge that takes the completing tick. In that cycle `c_set_o` is 8'hC0 (bit 7 request, bit 6 periodic flag). Otherwise `c_set_o` is 0.
- R9: A change of the rate code restarts the divider. The first event at the new rate needs a full new period.
- R10: Only clock edges with `tick_i` high advance the divider, so sparse ticks stretch the period in system cycles but not in ticks.
- R11: When a rate change and the tick that would complete the old period meet on the same edge, the restart wins. No event is produced, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz time-base enable, one cycle wide |
| ctrl_a_i | input | 8 | Control byte A: [3:0] rate code, [6:4] divider control, [7] unused |
| ctrl_b_i | input | 8 | Control byte B: [6] periodic enable, other bits unused |
| evt_o | output | 1 | One-cycle periodic event pulse |
| c_set_o | output | 8 | Status bits to set with the event (8'hC0 during a pulse) |

## Verification
A reprogram of the rate code can land on the very edge where a tick would complete the old period. The restart and the period wrap then compete in one cycle. The bench runs code 3 for three ticks, so the counter sits at its terminal value. It then raises `tick_i` and writes code 4 on the same edge. It expects no pulse after that edge, and the next pulse exactly eight ticks later. A design that lets the wrap through, or counts that tick, is caught by the pulse check or by the first-event position.

// File: rtl/periodic_irq_pkg.sv
package periodic_irq_pkg;
  localparam int unsigned RATE_W     = 4;
  localparam int unsigned DCC_W      = 3;
  localparam int unsigned CNT_W      = 15;
  localparam int unsigned ALIAS_MAX  = 2;
  localparam int unsigned ALIAS_ADD  = 7;
  localparam logic [7:0]  FLAG_MASK  = 8'hC0;

  typedef enum logic [1:0] {
    DIV_STOP  = 2'd0,
    DIV_RUN   = 2'd1,
    DIV_CLEAR = 2'd2
  } div_mode_e;

  function automatic logic [RATE_W-1:0] eff_code(input logic [RATE_W-1:0] code);
    if (code != '0 && code <= RATE_W'(ALIAS_MAX)) return code + RATE_W'(ALIAS_ADD);
    return code;
  endfunction
endpackage

// File: rtl/periodic_rate_dec.sv
module periodic_rate_dec
  import periodic_irq_pkg::*;
(
  input  logic [RATE_W-1:0] rate_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  term_o
);
  logic [RATE_W-1:0] eff;

  always_comb begin
    eff      = eff_code(rate_i);
    active_o = (rate_i != '0);
    term_o   = '0;
    if (eff != '0) begin
      for (int k = 0; k < CNT_W; k++) begin
        if (k < int'(eff) - 1) term_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/periodic_div_ctl.sv
module periodic_div_ctl
  import periodic_irq_pkg::*;
(
  input  logic [DCC_W-1:0] dcc_i,
  output div_mode_e        mode_o
);
  always_comb begin
    unique case (dcc_i[DCC_W-1 -: 2])
      2'b00:   mode_o = DIV_STOP;
      2'b11:   mode_o = DIV_CLEAR;
      default: mode_o = DIV_RUN;
    endcase
  end
endmodule

// File: rtl/periodic_tick_cnt.sv
module periodic_tick_cnt
  import periodic_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = adv_i && !clr_i && (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (adv_i) begin
      if (cnt_q == term_i) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import periodic_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] ctrl_a_i,
  input  logic [7:0] ctrl_b_i,
  output logic       evt_o,
  output logic [7:0] c_set_o
);
  localparam int unsigned EN_BIT  = 6;
  localparam int unsigned DCC_LSB = RATE_W;

  logic [RATE_W-1:0] rate;
  logic              en;
  logic [RATE_W-1:0] rate_q;
  logic              en_q;
  logic              restart;
  logic              active;
  logic [CNT_W-1:0]  term;
  div_mode_e         mode;
  logic              clr, adv, wrap;
  logic              evt_q;

  assign rate    = ctrl_a_i[RATE_W-1:0];
  assign en      = ctrl_b_i[EN_BIT];
  assign restart = (rate != rate_q) || (en != en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      en_q   <= 1'b0;
    end else begin
      rate_q <= rate;
      en_q   <= en;
    end
  end

  periodic_rate_dec u_rate_dec (
    .rate_i   (rate),
    .active_o (active),
    .term_o   (term)
  );

  periodic_div_ctl u_div_ctl (
    .dcc_i  (ctrl_a_i[DCC_LSB +: DCC_W]),
    .mode_o (mode)
  );

  // restart, inactive rate, disabled output and chain reset all clear the count
  assign clr = restart || !active || !en || (mode == DIV_CLEAR);
  assign adv = tick_i && (mode == DIV_RUN);

  periodic_tick_cnt u_tick_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv),
    .term_i (term),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= wrap;
  end

  assign evt_o   = evt_q;
  assign c_set_o = evt_q ? FLAG_MASK : 8'h00;
endmodule

// File: rtl/periodic_irq_gen_chk.sv
module periodic_irq_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [7:0] ctrl_a_i,
  input logic [7:0] ctrl_b_i,
  input logic       evt_o,
  input logic [7:0] c_set_o
);
  a_r1_code_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_a_i[3:0] == 4'd0) |-> !evt_o);

  a_r4_stopped_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_a_i[6:5] == 2'b00) |-> !evt_o);

  a_r5_cleared_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_a_i[6:5] == 2'b11) |-> !evt_o);

  a_r7_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl_b_i[6]) |-> !evt_o);

  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);

  a_r8_mask_only_with_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_set_o != 8'h00) |-> evt_o);

  a_r10_event_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(tick_i));

  a_r11_rate_change_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_a_i[3:0] != $past(ctrl_a_i[3:0])) |-> !evt_o);
endmodule

bind periodic_irq_gen periodic_irq_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .ctrl_a_i (ctrl_a_i),
  .ctrl_b_i (ctrl_b_i),
  .evt_o    (evt_o),
  .c_set_o  (c_set_o)
);

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] ctrl_a_i = 8'h20;
  logic [7:0] ctrl_b_i = 8'h00;
  logic       evt_o;
  logic [7:0] c_set_o;

  int n_chk = 0;
  int n_bad = 0;
  int mask_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  periodic_irq_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .ctrl_a_i(ctrl_a_i), .ctrl_b_i(ctrl_b_i),
    .evt_o(evt_o), .c_set_o(c_set_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk_i);
    ctrl_a_i = a;
    ctrl_b_i = b;
    tick_i   = 1'b0;
    repeat (2) @(posedge clk_i);
  endtask

  // drive n single-edge ticks, gap idle edges after each; report first event tick and count
  task automatic ticks(input int n, input int gap, output int first, output int cnt);
    first = 0;
    cnt   = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      @(posedge clk_i);
      #1;
      if (evt_o) begin
        cnt++;
        if (first == 0) first = i;
      end
      if (c_set_o != (evt_o ? 8'hC0 : 8'h00)) mask_bad++;
      @(negedge clk_i);
      tick_i = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk_i);
        #1;
        if (evt_o) cnt++;
      end
    end
  endtask

  function automatic logic [7:0] mk_a(input logic [2:0] dcc, input logic [3:0] rate);
    return {1'b0, dcc, rate};
  endfunction

  initial begin
    int f, c, p;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R8 reset evt", int'(evt_o), 0);
    chk("R8 reset mask", int'(c_set_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 sweep of all true rates
    for (int n = 3; n <= 15; n++) begin
      p = 1 << (n - 1);
      cfg(mk_a(3'b010, 4'(n)), 8'h00);
      cfg(mk_a(3'b010, 4'(n)), 8'h40);
      ticks((n <= 8) ? 2 * p : p, 0, f, c);
      chk($sformatf("R2 code %0d first", n), f, p);
      chk($sformatf("R2 code %0d count", n), c, (n <= 8) ? 2 : 1);
    end
    chk("R8 mask with pulses", mask_bad, 0);

    // R3 aliases
    cfg(mk_a(3'b010, 4'd1), 8'h40);
    ticks(128, 0, f, c);
    chk("R3 code 1 first", f, 128);
    cfg(mk_a(3'b010, 4'd2), 8'h40);
    ticks(256, 0, f, c);
    chk("R3 code 2 first", f, 256);

    // R1 code zero
    cfg(mk_a(3'b010, 4'd0), 8'h40);
    ticks(600, 0, f, c);
    chk("R1 code 0 count", c, 0);

    // R7 disable
    cfg(mk_a(3'b010, 4'd3), 8'h00);
    ticks(40, 0, f, c);
    chk("R7 disabled count", c, 0);
    cfg(mk_a(3'b010, 4'd4), 8'h40);
    ticks(5, 0, f, c);
    cfg(mk_a(3'b010, 4'd4), 8'h00);
    cfg(mk_a(3'b010, 4'd4), 8'h40);
    ticks(8, 0, f, c);
    chk("R7 re-enable first", f, 8);

    // R4 stop divider, both codes
    for (int d = 0; d < 2; d++) begin
      cfg(mk_a(3'(d), 4'd3), 8'h40);
      ticks(30, 0, f, c);
      chk($sformatf("R4 dcc %0d count", d), c, 0);
    end
    cfg(mk_a(3'b010, 4'd5), 8'h40);
    ticks(10, 0, f, c);
    cfg(mk_a(3'b000, 4'd5), 8'h40);
    ticks(20, 0, f, c);
    chk("R4 frozen count", c, 0);
    cfg(mk_a(3'b010, 4'd5), 8'h40);
    ticks(16, 0, f, c);
    chk("R4 resume first", f, 6);

    // R5 chain reset
    for (int d = 6; d < 8; d++) begin
      cfg(mk_a(3'b010, 4'd5), 8'h40);
      ticks(10, 0, f, c);
      cfg(mk_a(3'(d), 4'd5), 8'h40);
      ticks(20, 0, f, c);
      chk($sformatf("R5 dcc %0d count", d), c, 0);
      cfg(mk_a(3'b010, 4'd5), 8'h40);
      ticks(16, 0, f, c);
      chk($sformatf("R5 dcc %0d first", d), f, 16);
    end

    // R6 other running divider settings
    for (int d = 3; d < 6; d++) begin
      cfg(mk_a(3'(d), 4'd3), 8'h00);
      cfg(mk_a(3'(d), 4'd3), 8'h40);
      ticks(8, 0, f, c);
      chk($sformatf("R6 dcc %0d first", d), f, 4);
      chk($sformatf("R6 dcc %0d count", d), c, 2);
    end

    // R9 rate change mid-period
    cfg(mk_a(3'b010, 4'd5), 8'h40);
    ticks(10, 0, f, c);
    cfg(mk_a(3'b010, 4'd6), 8'h40);
    ticks(32, 0, f, c);
    chk("R9 new rate first", f, 32);

    // R10 sparse ticks
    cfg(mk_a(3'b010, 4'd3), 8'h00);
    cfg(mk_a(3'b010, 4'd4), 8'h40);
    ticks(16, 3, f, c);
    chk("R10 sparse first", f, 8);
    chk("R10 sparse count", c, 2);

    // R11 rate change on the completing tick edge
    cfg(mk_a(3'b010, 4'd3), 8'h40);
    ticks(3, 0, f, c);
    chk("R11 pre count", c, 0);
    @(negedge clk_i);
    ctrl_a_i = mk_a(3'b010, 4'd4);
    tick_i   = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R11 collision evt", int'(evt_o), 0);
    @(negedge clk_i);
    tick_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk("R11 after collision evt", int'(evt_o), 0);
    ticks(8, 0, f, c);
    chk("R11 new period first", f, 8);
    chk("R8 mask final", mask_bad, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule